// File: doc/BRIEF.md
# ARINC 429 Serial-to-Byte Receiver

This block takes ARINC 429 words from two logic-level rails that an external line receiver has already produced. A return-to-zero pulse on rail A carries a one, and a pulse on rail B carries a zero. The OR of the two rails acts as the bit clock. The block samples both rails on the gap clock and detects the rising edge of that OR. Each detected bit shifts into a 32-bit register. The first bit received ends up in the least significant position.

When the 32nd bit arrives, the word is copied into a holding register and a ready flag rises. The host then fetches the word as four bytes over an 8-bit bus by pulsing a read strobe. Each strobe clears the ready flag, and the end of each strobe moves the block to the next byte. A gap counter, also running on the gap clock, ends a word after a long enough idle period and flags words of the wrong length. An odd-parity check can be switched on or off. A test-mode input swaps in two test pins in place of the rails.

Top module: `arinc_byte_rx`

## Requirements
- R1: A rising edge of (A OR B) shifts in one bit: a one when A is high and a zero when B is high. The first bit of a word becomes word bit 0, which is bit 0 of byte 0.
- R2: With testMode=1, testA/testB stand in for railA/railB and the rails have no effect. With testMode=0, the test pins have no effect.
- R3: dataReady rises when the 32nd bit of a word is shifted in, and the full word is loaded into the holding register at the same time.
- R4: Reads return byte 0 (word bits 7:0) first and byte 3 (bits 31:24) last. The byte pointer advances when each strobe ends and wraps from byte 3 back to byte 0.
- R5: Each read strobe clears dataReady.
- R6: While readStb is low, dataOut is all zero and dataOe is low. While readStb is high, dataOe is high.
- R7: Parity is odd over all 32 bits. With parityEn=1, a completed word with an even number of ones sets wordError, and a word with an odd number clears it.
- R8: With parityEn=0, a completed word never sets wordError through parity, and its data is delivered unchanged.
- R9: Both rails idle for 4 bit times (16 gap clocks by default) ends the current word. A count other than 0 or 32 at that point sets wordError, and the bit counter restarts so that the next word is received correctly.
- R10: A word that completes before the previous one has been fully read overwrites the holding register, and the pointer returns to byte 0.
- R11: When rstN is low, dataReady, wordError, the byte pointer, the shift register and the holding register are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gapClk | input | 1 | Gap-timing and sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| railA | input | 1 | One-rail input from the line receiver |
| railB | input | 1 | Zero-rail input from the line receiver |
| testA | input | 1 | Test one-rail |
| testB | input | 1 | Test zero-rail |
| testMode | input | 1 | 1 selects the test pins as the bit source |
| parityEn | input | 1 | 1 enables the odd-parity check |
| readStb | input | 1 | Active-high read strobe |
| dataOut | output | 8 | Byte selected by the read pointer while the strobe is high, zero otherwise |
| dataOe | output | 1 | High while the bus is being driven |
| dataReady | output | 1 | A new word is waiting to be read |
| wordError | output | 1 | The last word ended with a length or parity fault |

## Verification
Properties checked on every cycle:
- A capture is always followed by a set ready flag and a pointer back at byte 0.
- A strobe that is not overlapped by a capture always clears the ready flag.
- A length fault always raises wordError.
- A capture with parity disabled always leaves wordError low.
- The end of a gap always resets the bit counter.

The following can only be shown by bench scenarios, because each depends on the exact value of a whole word:
- The bit-to-byte mapping and the order in which bytes are read.
- That the inactive rail pair has no effect.
- Overwriting a partly read word.
- The correct reception of a word after a short or long one.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef struct packed {
    logic shiftEn;    // one received bit this cycle
    logic shiftBit;   // its value
    logic capture;    // 32nd bit: load holding register
    logic lenErr;     // word closed by gap with bad count
    logic rdClear;    // strobe began
    logic rdAdvance;  // strobe ended
  } arx_ctl_t;
endpackage

// File: rtl/arx_control.sv
module arx_control
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BIT_CLKS  = 4,
  parameter int GAP_BITS  = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     railA,
  input  logic     railB,
  input  logic     testA,
  input  logic     testB,
  input  logic     testMode,
  input  logic     readStb,
  output arx_ctl_t ctl
);
  localparam int GAP_LIMIT = BIT_CLKS * GAP_BITS;
  localparam int GAP_W     = $clog2(GAP_LIMIT + 1);
  localparam int CNT_W     = $clog2(WORD_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_LIMIT - 1);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(GAP_LIMIT);

  logic srcA, srcB;
  logic aSync, bSync, aPrev, bPrev;
  logic rdSync, rdPrev;
  logic clkNow, clkPrev, bitEdge, gapEnd;
  logic [CNT_W-1:0] bitCnt;
  logic [GAP_W-1:0] idleCnt;

  assign srcA = testMode ? testA : railA;
  assign srcB = testMode ? testB : railB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aSync <= 1'b0; bSync <= 1'b0; aPrev <= 1'b0; bPrev <= 1'b0;
      rdSync <= 1'b0; rdPrev <= 1'b0;
    end else begin
      aSync <= srcA; bSync <= srcB; aPrev <= aSync; bPrev <= bSync;
      rdSync <= readStb; rdPrev <= rdSync;
    end
  end

  assign clkNow  = aSync | bSync;
  assign clkPrev = aPrev | bPrev;
  assign bitEdge = clkNow & ~clkPrev;
  assign gapEnd  = !clkNow && (idleCnt == GAP_END) && (bitCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      idleCnt <= '0;
    end else begin
      if (clkNow) idleCnt <= '0;
      else if (idleCnt != GAP_SAT) idleCnt <= idleCnt + 1'b1;
      if (gapEnd) bitCnt <= '0;
      else if (bitEdge && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.shiftEn   = bitEdge;
    ctl.shiftBit  = aSync;
    ctl.capture   = bitEdge && (bitCnt == LAST_IDX);
    ctl.lenErr    = gapEnd && (bitCnt != FULL_CNT);
    ctl.rdClear   = rdSync & ~rdPrev;
    ctl.rdAdvance = ~rdSync & rdPrev;
  end

  p_gap_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    gapEnd |=> (bitCnt == '0));
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.capture && ctl.lenErr));
endmodule

// File: rtl/arx_datapath.sv
module arx_datapath
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arx_ctl_t             ctl,
  input  logic                 parityEn,
  input  logic                 readStb,
  output logic [BYTE_BITS-1:0] dataOut,
  output logic                 dataReady,
  output logic                 wordError
);
  localparam int NUM_BYTES = WORD_BITS / BYTE_BITS;
  localparam int PTR_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_BYTES - 1);

  logic [WORD_BITS-1:0] shiftReg, holdReg, nextWord;
  logic [PTR_W-1:0]     rdPtr;
  logic [BYTE_BITS-1:0] byteLane [NUM_BYTES];

  assign nextWord = {ctl.shiftBit, shiftReg[WORD_BITS-1:1]};

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign byteLane[g] = holdReg[g*BYTE_BITS +: BYTE_BITS];
  end

  assign dataOut = readStb ? byteLane[rdPtr] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      holdReg   <= '0;
      rdPtr     <= '0;
      dataReady <= 1'b0;
      wordError <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftReg <= nextWord;
      if (ctl.capture) begin
        holdReg   <= nextWord;
        rdPtr     <= '0;
        dataReady <= 1'b1;
        wordError <= parityEn & ~(^nextWord);
      end else begin
        if (ctl.rdClear) dataReady <= 1'b0;
        if (ctl.rdAdvance) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
        if (ctl.lenErr) wordError <= 1'b1;
      end
    end
  end

  p_ready_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> dataReady);
  p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdClear && !ctl.capture) |=> !dataReady);
  p_ptr_home_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (rdPtr == '0));
  p_len_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lenErr |=> wordError);
  p_parity_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !parityEn) |=> !wordError);
endmodule

// File: rtl/arinc_byte_rx.sv
module arinc_byte_rx
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8,
  parameter int BIT_CLKS  = 4,
  parameter int GAP_BITS  = 4
) (
  input  logic                 gapClk,
  input  logic                 rstN,
  input  logic                 railA,
  input  logic                 railB,
  input  logic                 testA,
  input  logic                 testB,
  input  logic                 testMode,
  input  logic                 parityEn,
  input  logic                 readStb,
  output logic [BYTE_BITS-1:0] dataOut,
  output logic                 dataOe,
  output logic                 dataReady,
  output logic                 wordError
);
  arx_ctl_t ctl;

  arx_control #(.WORD_BITS(WORD_BITS), .BIT_CLKS(BIT_CLKS), .GAP_BITS(GAP_BITS)) u_ctl (
    .clk(gapClk), .rstN(rstN), .railA(railA), .railB(railB),
    .testA(testA), .testB(testB), .testMode(testMode), .readStb(readStb), .ctl(ctl)
  );

  arx_datapath #(.WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)) u_dp (
    .clk(gapClk), .rstN(rstN), .ctl(ctl), .parityEn(parityEn), .readStb(readStb),
    .dataOut(dataOut), .dataReady(dataReady), .wordError(wordError)
  );

  assign dataOe = readStb;
endmodule

// File: tb/tb_arinc_byte_rx.sv
module tb_arinc_byte_rx;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_WAIT   = 24;

  logic gapClk = 1'b0, rstN = 1'b0;
  logic railA = 0, railB = 0, testA = 0, testB = 0, testMode = 0, parityEn = 1, readStb = 0;
  logic [7:0] dataOut;
  logic dataOe, dataReady, wordError;
  int total = 0, bad = 0;

  arinc_byte_rx dut (.gapClk(gapClk), .rstN(rstN), .railA(railA), .railB(railB),
    .testA(testA), .testB(testB), .testMode(testMode), .parityEn(parityEn),
    .readStb(readStb), .dataOut(dataOut), .dataOe(dataOe),
    .dataReady(dataReady), .wordError(wordError));

  always #(CLK_PERIOD/2) gapClk = ~gapClk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic useTest);
    @(negedge gapClk);
    if (useTest) begin testA = b; testB = !b; end
    else begin railA = b; railB = !b; end
    repeat (2) @(negedge gapClk);
    if (useTest) begin testA = 0; testB = 0; end
    else begin railA = 0; railB = 0; end
    @(negedge gapClk);
  endtask

  task automatic sendWord(input logic [31:0] w, input int n, input logic useTest);
    for (int i = 0; i < n; i++) sendBit((i < 32) ? w[i] : 1'b1, useTest);
    repeat (2) @(negedge gapClk);
  endtask

  task automatic idleGap();
    repeat (GAP_WAIT) @(negedge gapClk);
  endtask

  task automatic readByte(output logic [7:0] b, output logic oe);
    @(negedge gapClk);
    readStb = 1;
    @(negedge gapClk);
    b = dataOut; oe = dataOe;
    readStb = 0;
    repeat (3) @(negedge gapClk);
  endtask

  task automatic readAll(input logic [31:0] w, input string tag);
    logic [7:0] b; logic oe;
    for (int k = 0; k < 4; k++) begin
      readByte(b, oe);
      chk({tag, " R4 byte"}, {24'd0, b}, {24'd0, w[k*8 +: 8]});
      chk("R6 oe high in strobe", {31'd0, oe}, 32'd1);
      if (k == 0) chk("R5 ready cleared by strobe", {31'd0, dataReady}, 32'd0);
      chk("R6 bus quiet", {23'd0, dataOe, dataOut}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge gapClk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    logic [7:0] b; logic oe;
    repeat (3) @(negedge gapClk);
    rstN = 1;
    @(negedge gapClk);
    chk("R11 reset ready", {31'd0, dataReady}, 32'd0);
    chk("R11 reset error", {31'd0, wordError}, 32'd0);
    chk("R6 reset bus", {23'd0, dataOe, dataOut}, 32'd0);

    // R1 R3 R4 R7: sweep of walking ones, zero and scrambled words
    for (int i = 0; i < 41; i++) begin
      if (i < 32) w = 32'd1 << i;
      else if (i == 32) w = 32'd0;
      else w = (i * 32'h9E3779B9) ^ (i << 3);
      sendWord(w, 32, 1'b0);
      chk("R3 ready after 32 bits", {31'd0, dataReady}, 32'd1);
      chk("R7 odd parity check", {31'd0, wordError}, {31'd0, ~(^w)});
      idleGap();
      chk("R9 full word no length error", {31'd0, wordError}, {31'd0, ~(^w)});
      readAll(w, "R1");
      readByte(b, oe);
      chk("R4 pointer wraps", {24'd0, b}, {24'd0, w[7:0]});
      repeat (3) readByte(b, oe);
    end

    // R8: parity disabled, even-parity words
    parityEn = 0;
    w = 32'h0000_0003; sendWord(w, 32, 1'b0);
    chk("R8 no parity error", {31'd0, wordError}, 32'd0);
    idleGap(); readAll(w, "R8");
    w = 32'hF0F0_A5A5; sendWord(w, 32, 1'b0);
    chk("R8 no parity error 2", {31'd0, wordError}, 32'd0);
    idleGap(); readAll(w, "R8");
    parityEn = 1;

    // R2: test mode with rail A held high
    testMode = 1; railA = 1;
    w = 32'h1234_5671; sendWord(w, 32, 1'b1);
    chk("R2 test mode ready", {31'd0, dataReady}, 32'd1);
    idleGap(); readAll(w, "R2 test");
    railA = 0; testMode = 0; testA = 1;
    w = 32'h8765_4320; sendWord(w, 32, 1'b0);
    chk("R2 normal mode ready", {31'd0, dataReady}, 32'd1);
    idleGap(); readAll(w, "R2 normal");
    testA = 0;
    repeat (4) @(negedge gapClk);

    // R9: short word then good word
    sendWord(32'hFFFF_FFFF, 20, 1'b0);
    chk("R9 short word no ready", {31'd0, dataReady}, 32'd0);
    idleGap();
    chk("R9 short word flagged", {31'd0, wordError}, 32'd1);
    w = 32'hCAFE_0001; sendWord(w, 32, 1'b0);
    chk("R9 restart after short", {31'd0, dataReady}, 32'd1);
    chk("R9 error cleared", {31'd0, wordError}, {31'd0, ~(^w)});
    idleGap(); readAll(w, "R9");

    // R9: long word
    w = 32'h0000_0007; sendWord(w, 34, 1'b0);
    idleGap();
    chk("R9 long word flagged", {31'd0, wordError}, 32'd1);
    readAll(w, "R9 long");

    // R10: overwrite partly read word
    w = 32'h1111_2222; sendWord(w, 32, 1'b0); idleGap();
    readByte(b, oe);
    w2 = 32'hABCD_EF01; sendWord(w2, 32, 1'b0); idleGap();
    chk("R10 ready on overwrite", {31'd0, dataReady}, 32'd1);
    readAll(w2, "R10");

    // R11: reset after a received word
    w = 32'h5555_AAAB; sendWord(w, 32, 1'b0); idleGap();
    @(negedge gapClk); rstN = 0;
    @(negedge gapClk); rstN = 1;
    @(negedge gapClk);
    chk("R11 ready cleared", {31'd0, dataReady}, 32'd0);
    chk("R11 error cleared", {31'd0, wordError}, 32'd0);
    readByte(b, oe);
    chk("R11 holding cleared", {24'd0, b}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule